// File: doc/BRIEF.md
# Translation Fault Capture Unit

This block sits beside an address-translation table walker and keeps a record of the first translation fault the walker reports. The walker pulses a fault strobe and presents, in the same cycle, the number of the stream that faulted, a one-hot cause code and the 64-bit device address that could not be translated. When no fault is held, the block latches all three and raises a level interrupt. Faults that arrive while a record is held are dropped, so software always sees the earliest one.

Software reaches the record through a 32-bit register port with a combinational read. Three words are visible: a status word (flag, stream and cause), and the faulting address split into a low and a high word. Software acknowledges the fault by writing the status value it read back to the status word. Every status bit is write-one-to-clear, so the write removes exactly what was reported. A fault that arrives in the same cycle as the write that clears the flag is kept, so no fault is lost in the gap between acknowledge and re-arm.

Top module: `xlat_fault_rec`

## Requirements
- R1: After reset the status word, both address words and the interrupt are zero.
- R2: The status word is read at offset 0x040. Bit 31 is the fault flag, bits 27:24 hold the faulting stream number, bits 11:0 hold the cause code as given by the walker (bit 0 no valid table base, bit 1 no first-level entry, bit 2 no second-level entry, bit 3 write-permission fault, bit 4 read-permission fault). All other bits read zero. A strobe while the flag is clear loads flag, stream and cause in the next cycle.
- R3: The captured address reads at offset 0x050 (bits 31:0) and offset 0x054 (bits 63:32), loaded in the same cycle as the status word.
- R4: The interrupt output equals the status fault flag in every cycle.
- R5: While the flag is set and not being cleared, further strobes change neither the status word nor either address word.
- R6: A write to offset 0x040 clears each status bit whose written data bit is one and leaves bits written as zero unchanged; clearing only cause bits keeps the flag and the interrupt set.
- R7: Writing back the exact status value that was read clears the status word to zero and drops the interrupt in the next cycle, while both address words keep their values.
- R8: A strobe in the same cycle as a status write with bit 31 set is captured: the next cycle shows the new flag, stream, cause and address.
- R9: Writes to offsets 0x050 and 0x054 have no effect, and reads from any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_strobe | input | 1 | One-cycle fault report from the walker |
| flt_stream | input | 4 | Stream number of the faulting access |
| flt_code | input | 12 | One-hot cause code |
| flt_addr | input | 64 | Faulting device address |
| reg_addr | input | 12 | Register byte offset |
| reg_wen | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Level interrupt, high while a fault is held |

## Verification
The assertions watch, on every cycle, that the interrupt matches the flag seen through the status read, that a held record and its address do not move under later strobes, that a capture from an empty state or on a same-cycle clear loads the walker's values, and that status writes clear only the written ones. Only the bench's scenarios show the register layout as software sees it: the reset values, the split of the address across two words, the write-back acknowledge that leaves the address in place, and that writes to the address words and reads of unused offsets are inert.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
   localparam int REG_W       = 32;
   localparam int FLAG_BIT    = 31;
   localparam int STREAM_LSB  = 24;
   localparam int STREAM_MAXW = 4;
   localparam int CODE_MAXW   = 12;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_STAT = 2'd1,
      SEL_ALO  = 2'd2,
      SEL_AHI  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/xfc_decode.sv
module xfc_decode #(
   parameter int          REG_AW   = 12,
   parameter logic [11:0] STAT_OFS = 12'h040,
   parameter logic [11:0] ALO_OFS  = 12'h050,
   parameter logic [11:0] AHI_OFS  = 12'h054
) (
   input  logic [REG_AW-1:0] reg_addr,
   output xfc_pkg::reg_sel_e sel
);
   import xfc_pkg::*;

   always_comb begin
      if (reg_addr == REG_AW'(STAT_OFS))     sel = SEL_STAT;
      else if (reg_addr == REG_AW'(ALO_OFS)) sel = SEL_ALO;
      else if (reg_addr == REG_AW'(AHI_OFS)) sel = SEL_AHI;
      else                                   sel = SEL_NONE;
   end
endmodule

// File: rtl/xfc_syndrome.sv
module xfc_syndrome #(
   parameter int STREAM_W = 4,
   parameter int CODE_W   = 12
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cap_en,
   input  logic [STREAM_W-1:0]       stream,
   input  logic [CODE_W-1:0]         code,
   input  logic                      wr_stat,
   input  logic [xfc_pkg::REG_W-1:0] wdata,
   output logic [xfc_pkg::REG_W-1:0] stat_q
);
   import xfc_pkg::*;

   logic [REG_W-1:0] live_mask;
   logic [REG_W-1:0] fresh;

   always_comb begin
      live_mask = '0;
      live_mask[FLAG_BIT] = 1'b1;
      live_mask[STREAM_LSB +: STREAM_W] = '1;
      live_mask[CODE_W-1:0] = '1;
   end

   always_comb begin
      fresh = '0;
      fresh[FLAG_BIT] = 1'b1;
      fresh[STREAM_LSB +: STREAM_W] = stream;
      fresh[CODE_W-1:0] = code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       stat_q <= '0;
      else if (cap_en)  stat_q <= fresh;
      else if (wr_stat) stat_q <= stat_q & ~(wdata & live_mask);
   end
endmodule

// File: rtl/xfc_addr_latch.sv
module xfc_addr_latch #(
   parameter int ADDR_W = 64
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cap_en,
   input  logic [ADDR_W-1:0]         flt_addr,
   output logic [xfc_pkg::REG_W-1:0] addr_lo,
   output logic [xfc_pkg::REG_W-1:0] addr_hi
);
   import xfc_pkg::*;
   localparam int HI_W = ADDR_W - REG_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_lo <= '0;
      else if (cap_en) addr_lo <= flt_addr[REG_W-1:0];
   end

   generate
      if (HI_W == REG_W) begin : g_full_hi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      addr_hi <= '0;
            else if (cap_en) addr_hi <= flt_addr[ADDR_W-1:REG_W];
         end
      end else begin : g_narrow_hi
         logic [HI_W-1:0] hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      hi_q <= '0;
            else if (cap_en) hi_q <= flt_addr[ADDR_W-1:REG_W];
         end
         assign addr_hi = {{(REG_W-HI_W){1'b0}}, hi_q};
      end
   endgenerate
endmodule

// File: rtl/xlat_fault_rec.sv
module xlat_fault_rec #(
   parameter int          STREAM_W = 4,
   parameter int          CODE_W   = 12,
   parameter int          ADDR_W   = 64,
   parameter int          REG_AW   = 12,
   parameter logic [11:0] STAT_OFS = 12'h040,
   parameter logic [11:0] ALO_OFS  = 12'h050,
   parameter logic [11:0] AHI_OFS  = 12'h054
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flt_strobe,
   input  logic [STREAM_W-1:0] flt_stream,
   input  logic [CODE_W-1:0]   flt_code,
   input  logic [ADDR_W-1:0]   flt_addr,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic                reg_wen,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   output logic                irq
);
   import xfc_pkg::*;

   generate
      if (STREAM_W < 1 || STREAM_W > STREAM_MAXW) begin : g_bad_stream
         $error("STREAM_W must be 1..4");
      end
      if (CODE_W < 1 || CODE_W > CODE_MAXW) begin : g_bad_code
         $error("CODE_W must be 1..12");
      end
      if (ADDR_W <= REG_W || ADDR_W > 2*REG_W) begin : g_bad_addr
         $error("ADDR_W must be 33..64");
      end
      if (REG_AW < 1 || REG_AW > 12) begin : g_bad_aw
         $error("REG_AW must be 1..12");
      end
   endgenerate

   reg_sel_e         sel;
   logic [REG_W-1:0] stat_q;
   logic [REG_W-1:0] addr_lo_q;
   logic [REG_W-1:0] addr_hi_q;
   logic             wr_stat;
   logic             clr_flag;
   logic             cap_en;

   xfc_decode #(
      .REG_AW(REG_AW), .STAT_OFS(STAT_OFS), .ALO_OFS(ALO_OFS), .AHI_OFS(AHI_OFS)
   ) dec_i (
      .reg_addr(reg_addr),
      .sel     (sel)
   );

   assign wr_stat  = reg_wen && (sel == SEL_STAT);
   assign clr_flag = wr_stat && reg_wdata[FLAG_BIT];
   assign cap_en   = flt_strobe && (!stat_q[FLAG_BIT] || clr_flag);

   xfc_syndrome #(.STREAM_W(STREAM_W), .CODE_W(CODE_W)) syn_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (cap_en),
      .stream (flt_stream),
      .code   (flt_code),
      .wr_stat(wr_stat),
      .wdata  (reg_wdata),
      .stat_q (stat_q)
   );

   xfc_addr_latch #(.ADDR_W(ADDR_W)) adr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (cap_en),
      .flt_addr(flt_addr),
      .addr_lo (addr_lo_q),
      .addr_hi (addr_hi_q)
   );

   always_comb begin
      unique case (sel)
         SEL_STAT: reg_rdata = stat_q;
         SEL_ALO:  reg_rdata = addr_lo_q;
         SEL_AHI:  reg_rdata = addr_hi_q;
         default:  reg_rdata = '0;
      endcase
   end

   assign irq = stat_q[FLAG_BIT];
endmodule

// File: rtl/xfc_checker.sv
module xfc_checker #(
   parameter int          STREAM_W = 4,
   parameter int          CODE_W   = 12,
   parameter int          ADDR_W   = 64,
   parameter int          REG_AW   = 12,
   parameter logic [11:0] STAT_OFS = 12'h040
) (
   input logic                clk,
   input logic                rst_n,
   input logic                flt_strobe,
   input logic [STREAM_W-1:0] flt_stream,
   input logic [CODE_W-1:0]   flt_code,
   input logic [ADDR_W-1:0]   flt_addr,
   input logic [REG_AW-1:0]   reg_addr,
   input logic                reg_wen,
   input logic [31:0]         reg_wdata,
   input logic [31:0]         reg_rdata,
   input logic                irq,
   input logic [31:0]         stat_q,
   input logic [31:0]         addr_lo,
   input logic [31:0]         addr_hi
);
   logic [63:0] held_addr;
   logic        stat_hit;
   logic        clr_wr;

   assign held_addr = {addr_hi, addr_lo};
   assign stat_hit  = (reg_addr == REG_AW'(STAT_OFS));
   assign clr_wr    = reg_wen && stat_hit && reg_wdata[31];

   // R4
   irq_matches_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_hit |-> (irq == reg_rdata[31]));

   // R2
   first_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_strobe && !stat_q[31]) |=>
         (stat_q[31] && stat_q[24 +: STREAM_W] == $past(flt_stream)
          && stat_q[CODE_W-1:0] == $past(flt_code)));

   // R5
   held_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[31] && !clr_wr) |=> $stable(held_addr));

   // R5
   held_flag_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[31] && !clr_wr) |=> stat_q[31]);

   // R8
   capture_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_strobe && clr_wr) |=>
         (irq && held_addr[ADDR_W-1:0] == $past(flt_addr)));

   // R6
   w1c_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wen && stat_hit && !flt_strobe) |=>
         ((stat_q & ~$past(stat_q)) == 32'h0));
endmodule

bind xlat_fault_rec xfc_checker #(
   .STREAM_W(STREAM_W), .CODE_W(CODE_W), .ADDR_W(ADDR_W),
   .REG_AW(REG_AW), .STAT_OFS(STAT_OFS)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .flt_strobe(flt_strobe),
   .flt_stream(flt_stream),
   .flt_code  (flt_code),
   .flt_addr  (flt_addr),
   .reg_addr  (reg_addr),
   .reg_wen   (reg_wen),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .irq       (irq),
   .stat_q    (stat_q),
   .addr_lo   (addr_lo_q),
   .addr_hi   (addr_hi_q)
);

// File: tb/xlat_fault_rec_tb_top.sv
module xlat_fault_rec_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flt_strobe = 1'b0;
   logic [3:0]  flt_stream = '0;
   logic [11:0] flt_code = '0;
   logic [63:0] flt_addr = '0;
   logic [11:0] reg_addr = '0;
   logic        reg_wen = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // reference model
   logic [31:0] m_stat = '0;
   logic [63:0] m_addr = '0;
   localparam logic [31:0] LIVE = 32'h8F00_0FFF;

   always #10 clk = ~clk;

   xlat_fault_rec dut_i (
      .clk(clk), .rst_n(rst_n), .flt_strobe(flt_strobe), .flt_stream(flt_stream),
      .flt_code(flt_code), .flt_addr(flt_addr), .reg_addr(reg_addr),
      .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   always @(posedge clk) begin
      if (rst_n) begin
         if (flt_strobe && (!m_stat[31] || (reg_wen && reg_addr == 12'h040 && reg_wdata[31]))) begin
            m_stat = 32'h8000_0000 | ({28'h0, flt_stream} << 24) | {20'h0, flt_code};
            m_addr = flt_addr;
         end else if (reg_wen && reg_addr == 12'h040) begin
            m_stat = m_stat & ~(reg_wdata & LIVE);
         end
      end
   end

   // R4: interrupt compared with the model every clock
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         checks++;
         if (irq !== m_stat[31]) begin
            errors++;
            $display("FAIL R4 irq: got %0b expected %0b", irq, m_stat[31]);
         end
      end
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      checks++;
      if (reg_rdata !== exp) begin
         errors++;
         $display("FAIL %s read 0x%03h: got 0x%08h expected 0x%08h", tag, a, reg_rdata, exp);
      end
   endtask

   task automatic step(input logic strb, input logic [3:0] s, input logic [11:0] c,
                       input logic [63:0] ad, input logic wen, input logic [11:0] wa,
                       input logic [31:0] wd);
      @(negedge clk);
      flt_strobe = strb; flt_stream = s; flt_code = c; flt_addr = ad;
      reg_wen = wen; reg_addr = wa; reg_wdata = wd;
      @(negedge clk);
      flt_strobe = 1'b0; reg_wen = 1'b0;
   endtask

   task automatic full_read(input string tag);
      chk_read(12'h040, m_stat, tag);
      chk_read(12'h050, m_addr[31:0], tag);
      chk_read(12'h054, m_addr[63:32], tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk_read(12'h040, 32'h0, "R1");
      chk_read(12'h050, 32'h0, "R1");
      chk_read(12'h054, 32'h0, "R1");

      // R2 R3 first capture
      step(1, 4'h5, 12'h004, 64'h0000_0012_3456_7000, 0, 12'h000, 0);
      chk_read(12'h040, 32'h8500_0004, "R2");
      chk_read(12'h050, 32'h3456_7000, "R3");
      chk_read(12'h054, 32'h0000_0012, "R3");

      // R5 later fault ignored
      step(1, 4'h9, 12'h010, 64'hDEAD_BEEF_CAFE_0000, 0, 12'h000, 0);
      chk_read(12'h040, 32'h8500_0004, "R5");
      chk_read(12'h050, 32'h3456_7000, "R5");
      chk_read(12'h054, 32'h0000_0012, "R5");

      // R6 partial clear of cause only
      step(0, 0, 0, 0, 1, 12'h040, 32'h0000_0004);
      chk_read(12'h040, 32'h8500_0000, "R6");

      // R5 fault while write without flag bit: not captured
      step(1, 4'h3, 12'h001, 64'h1, 1, 12'h040, 32'h0100_0000);
      chk_read(12'h040, 32'h8400_0000, "R5");
      chk_read(12'h050, 32'h3456_7000, "R5");

      // R7 write back read value
      step(0, 0, 0, 0, 1, 12'h040, 32'h8400_0000);
      chk_read(12'h040, 32'h0, "R7");
      chk_read(12'h050, 32'h3456_7000, "R7");
      chk_read(12'h054, 32'h0000_0012, "R7");

      // R9 writes to address words, read of unused offset
      step(0, 0, 0, 0, 1, 12'h050, 32'hFFFF_FFFF);
      step(0, 0, 0, 0, 1, 12'h054, 32'hFFFF_FFFF);
      chk_read(12'h050, 32'h3456_7000, "R9");
      chk_read(12'h054, 32'h0000_0012, "R9");
      chk_read(12'h060, 32'h0, "R9");
      chk_read(12'h044, 32'h0, "R9");

      // R2 each cause code, stream and address patterns
      for (int k = 0; k < 5; k++) begin
         step(1, 4'(k * 3), 12'(1 << k), {32'hA5A5_0000 + 32'(k), 32'h0001_4000 * 32'(k + 1)},
              0, 12'h000, 0);
         full_read("R2");
         step(0, 0, 0, 0, 1, 12'h040, m_stat);
         chk_read(12'h040, 32'h0, "R7");
      end

      // R8 fault on the same cycle as clear
      step(1, 4'h1, 12'h001, 64'h0000_0000_0010_0000, 0, 12'h000, 0);
      step(1, 4'hF, 12'h008, 64'hFFFF_0000_8000_4000, 1, 12'h040, 32'h8F00_0FFF);
      chk_read(12'h040, 32'h8F00_0008, "R8");
      chk_read(12'h050, 32'h8000_4000, "R8");
      chk_read(12'h054, 32'hFFFF_0000, "R8");

      // R8 same-cycle capture with the flag already clear
      step(0, 0, 0, 0, 1, 12'h040, 32'hFFFF_FFFF);
      chk_read(12'h040, 32'h0, "R6");
      step(1, 4'h7, 12'h002, 64'h1234_5678_9ABC_DEF0, 1, 12'h040, 32'h8000_0000);
      full_read("R8");

      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule